// File: doc/BRIEF.md
# Direct-Mapped Instruction Prefetch Cache

This block is a small read-only cache placed between a processor's instruction fetch stage and memory. The fetch stage asks for one 16-bit instruction word at a time. Each request carries a 32-bit logical address and a privilege flag that marks it as supervisor or user. The cache has 16 lines. Each line holds four 32-bit long words and keeps its own tag. There is one line per set, so the cache is direct-mapped.

A request that finds its word returns it in the same cycle. A request that does not find its word stalls. The cache then fetches one long word from memory over a valid/ready request channel and accepts the data on a response channel. It hands the requested half of that long word to the fetch stage in the cycle the data arrives, and stores the long word. Each long word has its own valid flag, so a miss fills only the one long word it needs.

Two plain control pins complete the interface. An enable pin switches the cache on and off. A one-cycle invalidate pin clears every stored entry.

Back-pressure rules:
- Fetch side: the fetch stage holds `req_valid`, `req_addr` and `req_super` steady until it sees `req_ready` high. `rsp_word` is meaningful only in that cycle.
- Memory request channel: the memory holds off a request by keeping `mem_req_ready` low. The cache keeps the request and its address steady until it is accepted.
- Memory response channel: this channel has no ready signal. The cache always takes `mem_rsp_valid` while a fill is outstanding.

Top module: `pfc_icache`

## Requirements
- R1: The request address is split as follows. Bits 7:4 pick one of 16 lines. Bits 3:2 pick one of the four long words in that line. Bits 31:8, together with `req_super`, form the stored tag.
- R2: A hit needs three things: `enable` is high, the selected line's tag matches bits 31:8 and `req_super`, and the selected long word's valid flag is set. On a hit, `req_ready` and `rsp_word` are driven in the same cycle as the request.
- R3: Address bit 1 chooses the half of the long word that is returned. When bit 1 is 0, bits 31:16 are returned. When bit 1 is 1, bits 15:0 are returned.
- R4: On a miss, `req_ready` stays low. In the next cycle, `mem_req_valid` rises with `mem_req_addr` equal to the request address with bits 1:0 cleared, and with `mem_req_super` equal to `req_super`. These stay stable until `mem_req_ready` is seen high.
- R5: At most one fill is outstanding at a time. After the request is accepted, `mem_req_valid` stays low and `req_ready` stays low until `mem_rsp_valid`. In that cycle, `req_ready` is high and `rsp_word` carries the selected half of `mem_rsp_data`.
- R6: A fill sets only the valid flag of the long word that was fetched. The other long words of the same line still miss unless they were valid before.
- R7: A fill into a line whose stored tag differs from the request's tag writes the new tag and leaves only the filled long word valid in that line.
- R8: The same address requested with the other privilege value misses.
- R9: A high `invalidate` at a clock edge clears all valid flags. If a fill completes in that same cycle, the invalidate takes priority and the fill is still returned to the fetch stage but is not kept.
- R10: While `enable` is low, every request misses and fills leave the stored contents unchanged. Entries stored before the cache was disabled hit again once `enable` returns high.
- R11: Reset clears all valid flags and leaves `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Cache on; when low, every request misses and nothing is stored |
| invalidate | input | 1 | Clears all valid flags at the clock edge |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Request completes this cycle; `rsp_word` is valid |
| req_addr | input | 32 | Logical byte address of the instruction word |
| req_super | input | 1 | 1 = supervisor request, 0 = user request |
| rsp_word | output | 16 | Instruction word returned |
| mem_req_valid | output | 1 | Fill request to memory |
| mem_req_ready | input | 1 | Memory accepts the fill request |
| mem_req_addr | output | 32 | Long-word aligned fill address |
| mem_req_super | output | 1 | Privilege flag of the fill |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_data | input | 32 | Fill long word |

## Verification
A hit is due combinationally, so the bench drives each request just after the falling edge and samples `req_ready` and `rsp_word` a moment later, before the next rising edge. A miss shows `mem_req_valid` one rising edge later. The bench checks it at the following falling edge and then at every falling edge while it holds `mem_req_ready` low. The returned word is due in the same cycle as `mem_rsp_valid`, so the bench samples it after driving the response and before the edge that consumes it. The bench updates its own tag and valid model only at that edge, so the next lookup sees the state the design will have.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_REQ  = 2'd1,
    FILL_WAIT = 2'd2
  } fill_state_e;

  // Big-endian half pick: bit 1 clear returns the upper half.
  function automatic logic [15:0] pick_half(input logic [31:0] lw, input logic a1);
    return a1 ? lw[15:0] : lw[31:16];
  endfunction

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
  parameter int NUM_LINES = 16,
  parameter int WPL       = 4,
  parameter int KEY_W     = 25,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int OFF_W    = $clog2(WPL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             invalidate,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [OFF_W-1:0] lk_off,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [KEY_W-1:0] wr_key
);

  logic [NUM_LINES-1:0][KEY_W-1:0] key_q;
  logic [NUM_LINES-1:0][WPL-1:0]   vld_q;
  logic [WPL-1:0]                  wr_onehot;
  logic                            key_differs;

  assign wr_onehot   = {{(WPL-1){1'b0}}, 1'b1} << wr_off;
  assign key_differs = (key_q[wr_idx] != wr_key);
  assign lk_hit      = vld_q[lk_idx][lk_off] && (key_q[lk_idx] == lk_key);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      key_q <= '0;
    end else if (invalidate) begin
      vld_q <= '0;
    end else if (wr_en) begin
      if (key_differs) begin
        key_q[wr_idx] <= wr_key;
        vld_q[wr_idx] <= wr_onehot;
      end else begin
        vld_q[wr_idx][wr_off] <= 1'b1;
      end
    end
  end

  assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate |=> (vld_q == '0));

  assert_fill_sets_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !invalidate) |=> vld_q[$past(wr_idx)][$past(wr_off)]);

  assert_replace_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !invalidate && key_differs) |=> ($countones(vld_q[$past(wr_idx)]) == 1));

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
  parameter int DEPTH   = 64,
  parameter int WORD_W  = 32,
  localparam int ADR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  wr_adr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADR_W-1:0]  rd_adr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_adr] <= wr_data;
  end

  assign rd_data = mem_q[rd_adr];

endmodule

// File: rtl/icache_fill_ctrl.sv
module icache_fill_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_super,
  input  logic              lookup_hit,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              idle,
  output logic              mem_req_valid,
  output logic              fill_done,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_super
);

  fill_state_e state_q;

  assign idle          = (state_q == FILL_IDLE);
  assign mem_req_valid = (state_q == FILL_REQ);
  assign fill_done     = (state_q == FILL_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FILL_IDLE;
      fill_addr  <= '0;
      fill_super <= 1'b0;
    end else begin
      unique case (state_q)
        FILL_IDLE: if (req_valid && !lookup_hit) begin
          fill_addr  <= req_addr;
          fill_super <= req_super;
          state_q    <= FILL_REQ;
        end
        FILL_REQ:  if (mem_req_ready) state_q <= FILL_WAIT;
        FILL_WAIT: if (mem_rsp_valid) state_q <= FILL_IDLE;
        default:   state_q <= FILL_IDLE;
      endcase
    end
  end

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(fill_addr) && $stable(fill_super)));

  assert_single_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: rtl/pfc_icache.sv
module pfc_icache
  import icache_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int WPL       = 4,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              invalidate,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_super,
  output logic [15:0]       rsp_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_super,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);

  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int OFF_W  = $clog2(WPL);
  localparam int LO     = OFF_W + 2;
  localparam int TAG_W  = ADDR_W - IDX_W - LO;
  localparam int KEY_W  = TAG_W + 1;
  localparam int DEPTH  = NUM_LINES * WPL;

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [OFF_W-1:0] lk_off, wr_off;
  logic [KEY_W-1:0] lk_key, wr_key;
  logic             store_hit, lookup_hit;
  logic             idle, fill_done, fill_super, store_we;
  logic [ADDR_W-1:0] fill_addr;
  logic [31:0]      rd_data;

  assign lk_idx = req_addr[LO +: IDX_W];
  assign lk_off = req_addr[2 +: OFF_W];
  assign lk_key = {req_addr[ADDR_W-1 -: TAG_W], req_super};

  assign wr_idx = fill_addr[LO +: IDX_W];
  assign wr_off = fill_addr[2 +: OFF_W];
  assign wr_key = {fill_addr[ADDR_W-1 -: TAG_W], fill_super};

  assign lookup_hit = enable && store_hit;
  assign store_we   = fill_done && enable;

  icache_tag_store #(.NUM_LINES(NUM_LINES), .WPL(WPL), .KEY_W(KEY_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .invalidate(invalidate),
    .lk_idx(lk_idx), .lk_off(lk_off), .lk_key(lk_key), .lk_hit(store_hit),
    .wr_en(store_we), .wr_idx(wr_idx), .wr_off(wr_off), .wr_key(wr_key)
  );

  icache_data_store #(.DEPTH(DEPTH), .WORD_W(32)) u_data (
    .clk(clk), .wr_en(store_we), .wr_adr({wr_idx, wr_off}), .wr_data(mem_rsp_data),
    .rd_adr({lk_idx, lk_off}), .rd_data(rd_data)
  );

  icache_fill_ctrl #(.ADDR_W(ADDR_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_super(req_super), .lookup_hit(lookup_hit), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .idle(idle), .mem_req_valid(mem_req_valid),
    .fill_done(fill_done), .fill_addr(fill_addr), .fill_super(fill_super)
  );

  assign mem_req_addr  = {fill_addr[ADDR_W-1:2], 2'b00};
  assign mem_req_super = fill_super;
  assign req_ready     = (idle && req_valid && lookup_hit) || fill_done;
  assign rsp_word      = fill_done ? pick_half(mem_rsp_data, fill_addr[1])
                                   : pick_half(rd_data, req_addr[1]);

  assert_ready_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (store_hit || fill_done));

  assert_disabled_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && req_valid && req_ready) |-> fill_done);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> !mem_req_valid);

endmodule

// File: tb/test_pfc_icache.sv
`timescale 1ns/1ps
module test_pfc_icache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1, invalidate = 1'b0;
  logic        req_valid = 1'b0, req_super = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] rsp_word;
  logic        mem_req_valid, mem_req_super;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  pfc_icache i_pfc_icache (
    .clk(clk), .rst_n(rst_n), .enable(enable), .invalidate(invalidate),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_super(req_super), .rsp_word(rsp_word), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_super(mem_req_super), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [24:0] m_key [16];
  logic [3:0]  m_vld [16];
  bit          m_en = 1'b1;

  function automatic logic [31:0] mem_fn(logic [31:0] a, logic s);
    return (a * 32'h9E3779B1) ^ (a >> 7) ^ (s ? 32'h5A5A0F0F : 32'h0);
  endfunction

  function automatic logic [15:0] half(logic [31:0] d, logic a1);
    return a1 ? d[15:0] : d[31:16];
  endfunction

  function automatic bit m_hit(logic [31:0] a, logic s);
    return m_en && m_vld[a[7:4]][a[3:2]] && (m_key[a[7:4]] == {a[31:8], s});
  endfunction

  task automatic chk(bit ok, string r, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic m_clear();
    for (int i = 0; i < 16; i++) m_vld[i] = 4'b0;
  endtask

  // One fetch; r names the requirement the hit/miss outcome exercises.
  task automatic fetch(input logic [31:0] a, input logic s, input int rq_dly,
                       input int rs_dly, input bit inv_rsp, input string r);
    logic [31:0] d;
    d = mem_fn({a[31:2], 2'b00}, s);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_super = s;
    #1;
    if (m_hit(a, s)) begin
      chk(req_ready == 1'b1, r, "hit ready", {31'b0, req_ready}, 32'd1);
      chk(rsp_word == half(d, a[1]), "R3", "hit word", {16'b0, rsp_word}, {16'b0, half(d, a[1])});
      @(posedge clk);
    end else begin
      chk(req_ready == 1'b0, r, "miss ready", {31'b0, req_ready}, 32'd0);
      @(negedge clk);
      chk(mem_req_valid == 1'b1, "R4", "fill req valid", {31'b0, mem_req_valid}, 32'd1);
      chk(mem_req_addr == {a[31:2], 2'b00}, "R4", "fill addr", mem_req_addr, {a[31:2], 2'b00});
      chk(mem_req_super == s, "R4", "fill priv", {31'b0, mem_req_super}, {31'b0, s});
      for (int k = 0; k < rq_dly; k++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == {a[31:2], 2'b00}, "R4", "fill held",
            mem_req_addr, {a[31:2], 2'b00});
        chk(req_ready == 1'b0, "R5", "stall ready", {31'b0, req_ready}, 32'd0);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int k = 0; k < rs_dly; k++) begin
        chk(mem_req_valid == 1'b0, "R5", "second fill", {31'b0, mem_req_valid}, 32'd0);
        chk(req_ready == 1'b0, "R5", "wait ready", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = d; invalidate = inv_rsp;
      #1;
      chk(req_ready == 1'b1, "R5", "fill ready", {31'b0, req_ready}, 32'd1);
      chk(rsp_word == half(d, a[1]), "R5", "fill word", {16'b0, rsp_word}, {16'b0, half(d, a[1])});
      @(posedge clk);
      if (inv_rsp) m_clear();
      else if (m_en) begin
        if (m_key[a[7:4]] != {a[31:8], s}) begin
          m_key[a[7:4]] = {a[31:8], s};
          m_vld[a[7:4]] = 4'b0;
        end
        m_vld[a[7:4]][a[3:2]] = 1'b1;
      end
      #1;
      mem_rsp_valid = 1'b0; invalidate = 1'b0;
    end
  endtask

  task automatic do_inval();
    @(negedge clk);
    req_valid = 1'b0; invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    m_clear();
  endtask

  task automatic set_en(bit b);
    @(negedge clk);
    req_valid = 1'b0; enable = b; m_en = b;
  endtask

  initial begin
    repeat (2000 * 20) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] a_a, a_b, a_c;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin m_key[i] = '0; m_vld[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_req_valid == 1'b0, "R11", "reset fill idle", {31'b0, mem_req_valid}, 32'd0);
    chk(req_ready == 1'b0, "R11", "reset ready", {31'b0, req_ready}, 32'd0);
    rst_n = 1'b1;
    a_a = 32'h1234_5670;
    a_b = 32'h0BAD_F0A8;
    a_c = 32'h7777_0030;
    fetch(a_a, 1'b0, 0, 0, 1'b0, "R11");
    fetch(a_a, 1'b0, 0, 0, 1'b0, "R2");
    fetch(a_a | 32'h2, 1'b0, 0, 0, 1'b0, "R3");
    fetch(a_a + 32'h4, 1'b0, 2, 1, 1'b0, "R6");
    fetch(a_a + 32'h4, 1'b0, 0, 0, 1'b0, "R6");
    fetch(a_a, 1'b1, 1, 3, 1'b0, "R8");
    fetch(a_a, 1'b0, 0, 0, 1'b0, "R7");
    fetch(a_a + 32'h4, 1'b0, 0, 0, 1'b0, "R7");
    fetch(a_a ^ 32'h0100_0000, 1'b0, 0, 0, 1'b0, "R1");
    do_inval();
    fetch(a_a, 1'b0, 0, 0, 1'b0, "R9");
    fetch(a_b, 1'b0, 0, 2, 1'b1, "R9");
    fetch(a_b, 1'b0, 0, 0, 1'b0, "R9");
    fetch(a_a, 1'b0, 0, 0, 1'b0, "R2");
    set_en(1'b0);
    fetch(a_a, 1'b0, 0, 0, 1'b0, "R10");
    fetch(a_c, 1'b0, 1, 1, 1'b0, "R10");
    set_en(1'b1);
    fetch(a_a, 1'b0, 0, 0, 1'b0, "R10");
    fetch(a_c, 1'b0, 0, 0, 1'b0, "R10");
    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra;
      logic [1:0]  tsel;
      int          roll;
      tsel = 2'($urandom_range(0, 2));
      ra = {22'h0_1A5C + {20'b0, tsel}, 4'($urandom), 2'($urandom), 1'($urandom), 1'b0};
      roll = $urandom_range(0, 99);
      if (roll < 2) do_inval();
      else if (roll < 5) set_en(~m_en);
      fetch(ra, 1'($urandom_range(0, 5) == 0), $urandom_range(0, 2),
            $urandom_range(0, 2), $urandom_range(0, 30) == 0, "R1");
    end
    set_en(1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule